// File: doc/BRIEF.md
# Rectangle Copy Engine

The engine moves a rectangle of 16-bit pixels between a pixel memory and a 32-bit word port. The memory holds 1024 columns by 512 rows. Each word on the port carries two pixels. A one-cycle start strobe supplies a position word, a size word and a direction flag. After that the host streams words in with a ready/valid handshake. A write sends data words. A read sends request words, and each request returns one assembled data word. The engine walks the rectangle in raster order and drives a synchronous single-port RAM interface with one pixel access per cycle. The RAM has a one-cycle read latency.

The host may stop supplying words at any point and resume later with bursts of any length. The engine keeps the current row, the column offset inside that row and the number of rows left, so the next burst continues where the previous one stopped. During a read an image-ready flag is high. A one-cycle completion pulse marks the issue of the final pixel. Starting a new transfer while one is still running raises an anomaly pulse, and the new transfer replaces the old one.

Top module: `rect_copy_engine`

## Requirements
- R1: The X origin is `posWord[9:0]` and the Y origin is `posWord[24:16]`. The first pixel access uses `memAddr = Y*1024 + X`, with the row in the upper 9 bits and the column in the lower 10 bits.
- R2: The width is `((sizeWord[9:0] - 1) & 0x3FF) + 1`. A field value of 0 gives a width of 1024.
- R3: The height is `((sizeWord[24:16] - 1) & 0x1FF) + 1`. A field value of 0 gives a height of 512. The number of rows left never grows except on a start.
- R4: Pixels are accessed in raster order. The column is `(X + offset) mod 1024` and wraps inside a row. After `width` pixels the offset returns to 0 and the row advances by one.
- R5: The row index wraps from 511 to 0.
- R6: For a write, each accepted word produces a write of bits 15:0 to the next pixel and then a write of bits 31:16 to the pixel after it. The upper half is dropped if the rectangle ends after the lower half.
- R7: For a read, each accepted request returns `rdData` with the first pixel in bits 15:0 and the second in bits 31:16. `rdValid` is high for exactly one cycle per request. Bits 31:16 are zero when the rectangle ends after the first pixel.
- R8: While no word is offered, the engine makes no memory access and keeps its position. The next word continues at the same column offset, including in the middle of a row.
- R9: `imgReady` rises on a start with `startIsRead = 1`. It stays low for a write start. It clears when the last row completes.
- R10: `done` pulses for one cycle after the final pixel access. From then on `dataReady` stays low until the next start.
- R11: A start while `busy` is high pulses `anomaly` in the following cycle, and the new parameters take effect. A start while idle leaves `anomaly` low.
- R12: After reset, `busy`, `dataReady`, `imgReady`, `done`, `anomaly`, `rdValid` and `memEn` are all low.
- R13: `dataReady` is high in the cycle after a start. After that it is high only while rows remain and no word is being processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | One-cycle start strobe |
| startIsRead | input | 1 | 1 = memory to port, 0 = port to memory |
| posWord | input | 32 | Origin: column in bits 9:0, row in bits 24:16 |
| sizeWord | input | 32 | Size: width field in bits 9:0, height field in bits 24:16 |
| dataValid | input | 1 | Host offers a data word (write) or a request (read) |
| dataIn | input | 32 | Two pixels for a write, lower half first |
| dataReady | output | 1 | Engine accepts a word this cycle |
| rdValid | output | 1 | Read word available |
| rdData | output | 32 | Two read pixels, first in bits 15:0 |
| memEn | output | 1 | Pixel memory access enable |
| memWe | output | 1 | Pixel memory write enable |
| memAddr | output | 19 | Pixel address, row in the upper bits |
| memWdata | output | 16 | Pixel write data |
| memRdata | input | 16 | Pixel read data, one cycle after the access |
| busy | output | 1 | Transfer or word in progress |
| imgReady | output | 1 | Read transfer in progress |
| done | output | 1 | Final pixel issued (pulse) |
| anomaly | output | 1 | Start arrived while busy (pulse) |

## Verification
The bench builds the engine with its default column and row widths of 10 and 9 bits. These widths are needed for the mask-and-add decode to produce its true maxima of 1024 and 512. They also let column wrap at 1023 and row wrap at 511 appear in short transfers. The memory model is sparse, so the bench can run a full-width row and a full-height column in full and still stay within budget. Odd pixel totals, row-straddling words, idle gaps in the middle of a row and an interrupted transfer all go through the same access and word scoreboard.

// File: rtl/rect_copy_pkg.sv
package rect_copy_pkg;

  // Sequencer phase for one 32-bit word (two pixels)
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_OUT  = 2'd3
  } phase_e;

  // Strobes from the sequencer to the word datapath
  typedef struct packed {
    logic loadWord;  // latch an incoming write word
    logic selHi;     // present the upper pixel on the write bus
    logic capLo;     // capture the first returned pixel
    logic capHi;     // assemble and emit the read word
    logic zeroHi;    // no second pixel was fetched for this word
  } dp_ctl_t;

endpackage

// File: rtl/rect_copy_ctrl.sv
module rect_copy_ctrl
  import rect_copy_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic            startIsRead,
  input  logic [31:0]     posWord,
  input  logic [31:0]     sizeWord,
  input  logic            dataValid,
  output logic            dataReady,
  output logic            memEn,
  output logic            memWe,
  output logic [XW+YW-1:0] memAddr,
  output dp_ctl_t         dpCtl,
  output logic            busy,
  output logic            imgReady,
  output logic            done,
  output logic            anomaly
);

  localparam int Y_LSB = 16;
  localparam logic [XW-1:0] X_ONE = 1;
  localparam logic [YW-1:0] Y_ONE = 1;
  localparam logic [XW:0]   W_ONE = 1;
  localparam logic [YW:0]   H_ONE = 1;

  logic [XW-1:0] xOrg, colOff;
  logic [YW-1:0] rowCur;
  logic [XW:0]   widthQ;
  logic [YW:0]   rowsLeft;
  logic          readMode, hiIssued;
  phase_e        phase;

  wire unusedPorts = ^{posWord, sizeWord};

  // Size decode: minus one, mask to field width, plus one
  logic [XW-1:0] wM1;
  logic [YW-1:0] hM1;
  logic [XW:0]   widthDec;
  logic [YW:0]   heightDec;
  assign wM1       = sizeWord[XW-1:0] - X_ONE;
  assign hM1       = sizeWord[Y_LSB +: YW] - Y_ONE;
  assign widthDec  = {1'b0, wM1} + W_ONE;
  assign heightDec = {1'b0, hM1} + H_ONE;

  logic active, accept, accessNow, lastCol;
  assign active    = (rowsLeft != '0);
  assign dataReady = (phase == PH_IDLE) && active;
  assign accept    = dataReady && dataValid && !startValid;
  assign accessNow = (phase == PH_LO) || ((phase == PH_HI) && active);
  assign lastCol   = (({1'b0, colOff} + W_ONE) == widthQ);

  assign memEn   = accessNow;
  assign memWe   = accessNow && !readMode;
  assign memAddr = {rowCur, xOrg + colOff};
  assign busy    = active || (phase != PH_IDLE);

  always_comb begin
    dpCtl          = '0;
    dpCtl.loadWord = accept && !readMode;
    dpCtl.selHi    = (phase == PH_HI);
    dpCtl.capLo    = (phase == PH_HI) && readMode;
    dpCtl.capHi    = (phase == PH_OUT);
    dpCtl.zeroHi   = !hiIssued;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOrg     <= '0;
      colOff   <= '0;
      rowCur   <= '0;
      widthQ   <= '0;
      rowsLeft <= '0;
      readMode <= 1'b0;
      hiIssued <= 1'b0;
      phase    <= PH_IDLE;
      imgReady <= 1'b0;
      done     <= 1'b0;
      anomaly  <= 1'b0;
    end else begin
      done    <= 1'b0;
      anomaly <= 1'b0;
      if (startValid) begin
        xOrg     <= posWord[XW-1:0];
        rowCur   <= posWord[Y_LSB +: YW];
        widthQ   <= widthDec;
        rowsLeft <= heightDec;
        colOff   <= '0;
        readMode <= startIsRead;
        imgReady <= startIsRead;
        hiIssued <= 1'b0;
        phase    <= PH_IDLE;
        anomaly  <= busy;
      end else begin
        case (phase)
          PH_IDLE: if (accept) phase <= PH_LO;
          PH_LO:   phase <= PH_HI;
          PH_HI: begin
            hiIssued <= active;
            phase    <= readMode ? PH_OUT : PH_IDLE;
          end
          PH_OUT:  phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
        if (accessNow) begin
          if (lastCol) begin
            colOff   <= '0;
            rowCur   <= rowCur + Y_ONE;
            rowsLeft <= rowsLeft - H_ONE;
            if (rowsLeft == H_ONE) begin
              imgReady <= 1'b0;
              done     <= 1'b1;
            end
          end else begin
            colOff <= colOff + X_ONE;
          end
        end
      end
    end
  end

  // R3: remaining rows only shrink between starts
  p_rows_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(startValid) |-> (rowsLeft <= $past(rowsLeft)));

  // R9: image-ready only rises from a read start
  p_img_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(imgReady) |-> $past(startValid && startIsRead));

  // R10: completion leaves the port closed and image-ready low
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!dataReady && !imgReady));

  // R11: anomaly is always caused by a start strobe
  p_anom_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    anomaly |-> $past(startValid));

endmodule

// File: rtl/rect_copy_dp.sv
module rect_copy_dp
  import rect_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_ctl_t     dpCtl,
  input  logic [31:0] dataIn,
  input  logic [15:0] memRdata,
  output logic [15:0] memWdata,
  output logic [31:0] rdData,
  output logic        rdValid
);

  logic [31:0] wordReg;
  logic [15:0] loReg;

  assign memWdata = dpCtl.selHi ? wordReg[31:16] : wordReg[15:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      loReg   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtl.capHi;
      if (dpCtl.loadWord) wordReg <= dataIn;
      if (dpCtl.capLo)    loReg   <= memRdata;
      if (dpCtl.capHi)    rdData  <= {dpCtl.zeroHi ? 16'h0000 : memRdata, loReg};
    end
  end

  // R7: each read word is announced for a single cycle
  p_rdvalid_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7: the upper pixel is assembled right after the lower one is taken
  p_cap_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.capHi |-> $past(dpCtl.capLo));

endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
  import rect_copy_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             startIsRead,
  input  logic [31:0]      posWord,
  input  logic [31:0]      sizeWord,
  input  logic             dataValid,
  input  logic [31:0]      dataIn,
  output logic             dataReady,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             memEn,
  output logic             memWe,
  output logic [XW+YW-1:0] memAddr,
  output logic [15:0]      memWdata,
  input  logic [15:0]      memRdata,
  output logic             busy,
  output logic             imgReady,
  output logic             done,
  output logic             anomaly
);

  dp_ctl_t dpCtl;

  rect_copy_ctrl #(.XW(XW), .YW(YW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startIsRead(startIsRead),
    .posWord(posWord), .sizeWord(sizeWord),
    .dataValid(dataValid), .dataReady(dataReady),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .dpCtl(dpCtl), .busy(busy), .imgReady(imgReady),
    .done(done), .anomaly(anomaly)
  );

  rect_copy_dp dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .dataIn(dataIn), .memRdata(memRdata), .memWdata(memWdata),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/rect_copy_engine_tb_top.sv
module rect_copy_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 10;
  localparam int YW = 9;
  localparam int AW = XW + YW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, startValid, startIsRead, dataValid;
  logic [31:0] posWord, sizeWord, dataIn, rdData;
  logic dataReady, rdValid, memEn, memWe, busy, imgReady, done, anomaly;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;

  rect_copy_engine #(.XW(XW), .YW(YW)) dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startIsRead(startIsRead),
    .posWord(posWord), .sizeWord(sizeWord), .dataValid(dataValid), .dataIn(dataIn),
    .dataReady(dataReady), .rdValid(rdValid), .rdData(rdData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .imgReady(imgReady), .done(done),
    .anomaly(anomaly)
  );

  // Sparse synchronous pixel memory
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[int'(memAddr)] = memWdata;
      else memRdata <= ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 16'h0000;
    end
  end

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [15:0]   data;
  } acc_t;

  acc_t        accQ[$];
  logic [31:0] wordQ[$];
  logic [15:0] shadow [int];
  int checks = 0, errors = 0, doneCnt = 0, expDone = 0;
  bit expRead = 1'b0;
  int cx0, cy, coff, cw, ch;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] shRead(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  // Bench cursor, computed from R1-style decode rules
  task automatic nextPix(output int a, output bit v);
    if (ch == 0) begin
      v = 1'b0; a = 0;
    end else begin
      v = 1'b1;
      a = cy * 1024 + ((cx0 + coff) % 1024);
      coff++;
      if (coff == cw) begin
        coff = 0; cy = (cy + 1) % 512; ch--;
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    acc_t e;
    logic [31:0] w;
    if (rstN) begin
      if (done) doneCnt++;
      if (memEn) begin
        check(imgReady == expRead, "R9", "imgReady during access", 64'(imgReady), 64'(expRead));
        if (accQ.size() == 0) begin
          check(1'b0, "R8", "unexpected access", 64'({memWe, memAddr}), 64'(0));
        end else begin
          e = accQ.pop_front();
          check(memWe == e.we && memAddr == e.addr && (!e.we || memWdata == e.data),
                "R4 R6", "pixel access {we,addr,data}",
                64'({memWe, memAddr, memWdata}), 64'({e.we, e.addr, e.we ? e.data : memWdata}));
        end
      end
      if (rdValid) begin
        if (wordQ.size() == 0) begin
          check(1'b0, "R7", "unexpected read word", 64'(rdData), 64'(0));
        end else begin
          w = wordQ.pop_front();
          check(rdData == w, "R7", "read word", 64'(rdData), 64'(w));
        end
      end
    end
  end

  task automatic startXfer(input logic [31:0] pos, input logic [31:0] size,
                           input bit rd, input bit expAnom);
    @(negedge clk);
    startValid = 1'b1; startIsRead = rd; posWord = pos; sizeWord = size;
    @(negedge clk);
    startValid = 1'b0;
    check(anomaly == expAnom, "R11", "anomaly after start", 64'(anomaly), 64'(expAnom));
    check(dataReady == 1'b1, "R13", "ready after start", 64'(dataReady), 64'(1));
    check(imgReady == rd, "R9", "imgReady after start", 64'(imgReady), 64'(rd));
    cx0 = int'(pos & 32'h3FF);
    cy  = int'((pos >> 16) & 32'h1FF);
    cw  = int'(((size - 32'd1) & 32'h3FF) + 32'd1);
    ch  = int'((((size >> 16) - 32'd1) & 32'h1FF) + 32'd1);
    coff = 0;
    expRead = rd;
  endtask

  task automatic waitReady();
    for (int n = 0; n < 5000 && !dataReady; n++) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] data, input int gap);
    int a0, a1; bit v0, v1; acc_t e;
    repeat (gap) @(negedge clk);
    waitReady();
    nextPix(a0, v0); nextPix(a1, v1);
    if (v0) begin
      e.we = 1'b1; e.addr = a0[AW-1:0]; e.data = data[15:0];
      accQ.push_back(e); shadow[a0] = data[15:0];
    end
    if (v1) begin
      e.we = 1'b1; e.addr = a1[AW-1:0]; e.data = data[31:16];
      accQ.push_back(e); shadow[a1] = data[31:16];
    end
    dataValid = 1'b1; dataIn = data;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic sendReq(input int gap);
    int a0, a1; bit v0, v1; acc_t e;
    repeat (gap) @(negedge clk);
    waitReady();
    nextPix(a0, v0); nextPix(a1, v1);
    e.we = 1'b0; e.data = 16'h0000;
    e.addr = a0[AW-1:0]; accQ.push_back(e);
    if (v1) begin e.addr = a1[AW-1:0]; accQ.push_back(e); end
    wordQ.push_back({v1 ? shRead(a1) : 16'h0000, shRead(a0)});
    dataValid = 1'b1; dataIn = 32'hDEAD_BEEF;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    expDone++;
    check(doneCnt == expDone, "R10", "done pulse count", 64'(doneCnt), 64'(expDone));
    check(!dataReady, "R10", "ready after completion", 64'(dataReady), 64'(0));
    check(!imgReady, "R9", "imgReady after completion", 64'(imgReady), 64'(0));
    check(accQ.size() == 0 && wordQ.size() == 0, "R8", "scoreboard drained",
          64'(accQ.size() + wordQ.size()), 64'(0));
  endtask

  task automatic writeAll(input logic [31:0] pos, input logic [31:0] size,
                          input logic [15:0] seed, input int gapMod);
    int words;
    startXfer(pos, size, 1'b0, 1'b0);
    words = (cw * ch + 1) / 2;
    for (int i = 0; i < words; i++)
      sendWord({seed ^ 16'(2*i+1), seed ^ 16'(2*i)}, gapMod > 0 ? (i % gapMod) : 0);
    waitIdle();
  endtask

  task automatic readAll(input logic [31:0] pos, input logic [31:0] size, input int gapMod);
    int words;
    startXfer(pos, size, 1'b1, 1'b0);
    words = (cw * ch + 1) / 2;
    for (int i = 0; i < words; i++)
      sendReq(gapMod > 0 ? (i % gapMod) : 0);
    waitIdle();
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; startValid = 1'b0; startIsRead = 1'b0; dataValid = 1'b0;
    posWord = '0; sizeWord = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check({busy, dataReady, imgReady, done, anomaly, rdValid, memEn} == 7'b0,
          "R12", "outputs after reset",
          64'({busy, dataReady, imgReady, done, anomaly, rdValid, memEn}), 64'(0));

    // R1 R2 R6: odd width, words straddle rows
    writeAll({16'd7, 16'd5}, {16'd2, 16'd3}, 16'h1000, 0);
    readAll ({16'd7, 16'd5}, {16'd2, 16'd3}, 0);

    // R4: column wrap at 1023, odd total so last upper half is dropped / zero (R7)
    writeAll({16'd3, 16'd1022}, {16'd1, 16'd3}, 16'h2200, 0);
    readAll ({16'd3, 16'd1022}, {16'd1, 16'd3}, 2);

    // R5: row wrap from 511 to 0
    writeAll({16'd511, 16'd100}, {16'd2, 16'd2}, 16'h3300, 0);
    readAll ({16'd511, 16'd100}, {16'd2, 16'd2}, 0);

    // R2: width field 0 selects 1024 columns
    writeAll({16'd20, 16'd0}, {16'd1, 16'd0}, 16'h4400, 0);

    // R3 R5: height field 0 selects 512 rows
    writeAll({16'd300, 16'd7}, {16'd0, 16'd1}, 16'h5500, 0);
    readAll ({16'd300, 16'd7}, {16'd0, 16'd1}, 0);

    // R8: idle gaps between words, mid-row resume
    writeAll({16'd50, 16'd200}, {16'd3, 16'd5}, 16'h6600, 4);
    readAll ({16'd50, 16'd200}, {16'd3, 16'd5}, 5);

    // R11: restart while a transfer is unfinished
    startXfer({16'd100, 16'd0}, {16'd4, 16'd4}, 1'b0, 1'b0);
    sendWord(32'hABCD_1234, 0);
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R11", "busy mid-transfer", 64'(busy), 64'(1));
    check(accQ.size() == 0, "R8", "pending accesses before restart", 64'(accQ.size()), 64'(0));
    startXfer({16'd50, 16'd200}, {16'd3, 16'd5}, 1'b1, 1'b1);
    begin
      int words;
      words = (cw * ch + 1) / 2;
      for (int i = 0; i < words; i++) sendReq(1);
    end
    waitIdle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule